// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block sequences each clock cycle of a synchronous SRAM that has two byte lanes and a registered read pipeline. When the processor strobe or the controller strobe starts a cycle, the block latches the three chip enables and decides whether the memory is selected. It then issues registered read or write strobes to the array, with a per-lane write mask, at the address delivered by an external burst sequencer. Chip enable changes have no effect between new-address cycles.

Read data from the array passes through an output register before it reaches the data pins. The pins are driven only when the asynchronous, active-low output enable is low and the output register holds data from a read. A write cycle, or the first cycle of a read after a deselect, leaves the pins released. A synchronous sleep request stops all array activity two cycles after it is raised. Operation resumes two cycles after it is dropped, with the device deselected and the pins undriven. The block also tells the burst sequencer when to step to the next address.

Top module: `sram_burst_ctl`

## Requirements
- R1: A new-address cycle selects the memory only when ce1N=0, ce2=1 and ce3N=0. Any other combination deselects it. A deselected memory issues no array strobe until a later new-address cycle selects it.
- R2: The chip enables are ignored on cycles that load no new address. A selected burst keeps accessing the array whatever they show.
- R3: The processor strobe (adspN=0) is ignored while ce1N=1. When both strobes are low and ce1N=0, only the processor strobe acts. When the processor strobe is ignored and adscN=0, the controller strobe loads the address.
- R4: With gwN=0 on a write-capable cycle, both lanes are written (arrByteEn=2'b11), whatever bweN and bwN show.
- R5: With gwN=1 and bweN=0, lane i is written when bwN[i]=0 (arrByteEn[i]=1). With gwN=1 and bweN=1, or with no lane selected, the cycle is a read.
- R6: A cycle started by the processor strobe is always a read, whatever the write enables show. A cycle started by the controller strobe with the write enables active is a write.
- R7: The array strobes arrRd, arrWr, arrByteEn and arrAddr change after the edge that samples the cycle. Read data for that address appears on dqOut after the next edge.
- R8: dqOe follows oeN without waiting for a clock: oeN=1 forces dqOe=0 at once.
- R9: dqOe stays 0 in the cycle after a write, and in the first cycle of a read that starts from the deselected state.
- R10: sleep is sampled on rising edges. The first two edges at which it is high are still processed. From the next edge on, all synchronous inputs are ignored, arrRd and arrWr stay 0 and dqOe is 0.
- R11: After sleep drops, the first two edges are still ignored and inputs are processed again from the third. The block wakes deselected, with dqOe=0 until a new read completes.
- R12: burstStep=1 only while the memory is selected and awake, no new address loads in the current cycle, and advN=0.
- R13: Reset (rstN=0) leaves the block deselected and awake, with arrRd=0, arrWr=0, arrByteEn=0 and dqOe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance request, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES (2) | Per-lane byte selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addrIn | input | ADDR_W (16) | Address from the burst sequencer |
| arrRdData | input | LANES*LANE_W (18) | Read data from the array |
| arrAddr | output | ADDR_W (16) | Registered array address |
| arrRd | output | 1 | Array read strobe |
| arrWr | output | 1 | Array write strobe |
| arrByteEn | output | LANES (2) | Per-lane write mask |
| burstStep | output | 1 | Step request to the burst sequencer |
| dqOut | output | LANES*LANE_W (18) | Output register contents |
| dqOe | output | 1 | Drive enable for the data pins |

## Verification
A table of cycle patterns covers the following:
- processor-strobe and controller-strobe loads with each chip enable combination;
- both strobes together, with ce1N low and with it high;
- continuation cycles with global write, with each single lane, and with byte writes disabled.

Together these separate write-enable decoding from strobe priority, and real deselects from ignored strobes. Directed sequences follow read data through the output register and check how dqOe behaves after writes, after deselects and under an asynchronous oeN change. A last sequence runs a selected read burst into sleep and back out and checks the exact edge at which activity stops and restarts.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  // Strobes from the cycle control to the read datapath
  typedef struct packed {
    logic rdIssued;  // array read strobe is active this cycle
    logic asleep;    // sleep has taken effect
  } ctlStrobe_t;
endpackage

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              arrRd,
  output logic              arrWr,
  output logic [LANES-1:0]  arrByteEn,
  output logic              burstStep,
  output ctlStrobe_t        strb
);
  localparam int SLEEP_STAGES = 2;

  logic [SLEEP_STAGES-1:0] sleepPipe;
  logic                    asleep;
  logic                    selected;
  logic                    active, adspStart, adscStart, loadNow, ceOk;
  logic                    accessNow, wrNow, rdNow;
  logic [LANES-1:0]        laneWant;

  assign asleep    = sleepPipe[SLEEP_STAGES-1];
  assign active    = !asleep;
  // processor strobe counts only with ce1N low; it wins over the controller strobe
  assign adspStart = active && !adspN && !ce1N;
  assign adscStart = active && !adscN && !adspStart;
  assign loadNow   = adspStart || adscStart;
  assign ceOk      = !ce1N && ce2 && !ce3N;
  assign accessNow = active && (loadNow ? ceOk : selected);

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign laneWant[gi] = !gwN || (!bweN && !bwN[gi]);
    end
  endgenerate

  assign wrNow     = accessNow && !adspStart && (|laneWant);
  assign rdNow     = accessNow && !wrNow;
  assign burstStep = active && selected && !loadNow && !advN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPipe <= '0;
      selected  <= 1'b0;
      arrRd     <= 1'b0;
      arrWr     <= 1'b0;
      arrByteEn <= '0;
      arrAddr   <= '0;
    end else begin
      sleepPipe <= {sleepPipe[SLEEP_STAGES-2:0], sleep};
      if (!active)      selected <= 1'b0;
      else if (loadNow) selected <= ceOk;
      arrRd     <= rdNow;
      arrWr     <= wrNow;
      arrByteEn <= wrNow ? laneWant : '0;
      if (accessNow) arrAddr <= addrIn;
    end
  end

  assign strb.rdIssued = arrRd;
  assign strb.asleep   = asleep;

  // R6: a processor-strobe start is never a write
  a_r6_adsp_read: assert property (@(posedge clk) disable iff (!rstN)
    adspStart |=> !arrWr);
  // R10: no array strobes once asleep
  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    asleep |=> (!arrRd && !arrWr));
  // R5: a write always carries at least one lane
  a_r5_write_has_lane: assert property (@(posedge clk) disable iff (!rstN)
    arrWr |-> (arrByteEn != '0));
  // R7: read and write strobes are exclusive, reads carry no mask
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    arrRd |-> (!arrWr && arrByteEn == '0));
  // R1: a deselecting load issues no access
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    (loadNow && !ceOk) |=> (!arrRd && !arrWr));
endmodule

// File: rtl/sram_rd_path.sv
module sram_rd_path
  import sram_ctl_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              oeN,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  logic outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dqOut    <= '0;
    end else begin
      outValid <= strb.rdIssued && !strb.asleep;
      if (strb.rdIssued) dqOut <= arrRdData;
    end
  end

  // asynchronous enable, masked when no read data is held or while asleep
  assign dqOe = !oeN && outValid && !strb.asleep;

  // R8: output enable high always releases the pins
  a_r8_oe_release: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOe);
  // R9: no drive in the cycle after a non-read
  a_r9_no_drive_after_nonread: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdIssued |=> !dqOe);
  // R10: no drive while asleep
  a_r10_sleep_hiz: assert property (@(posedge clk) disable iff (!rstN)
    strb.asleep |-> !dqOe);
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    adspN,
  input  logic                    adscN,
  input  logic                    advN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    oeN,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] arrRdData,
  output logic [ADDR_W-1:0]       arrAddr,
  output logic                    arrRd,
  output logic                    arrWr,
  output logic [LANES-1:0]        arrByteEn,
  output logic                    burstStep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);
  localparam int DATA_W = LANES * LANE_W;

  ctlStrobe_t strb;

  sram_cyc_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .sleep(sleep), .addrIn(addrIn), .arrAddr(arrAddr), .arrRd(arrRd),
    .arrWr(arrWr), .arrByteEn(arrByteEn), .burstStep(burstStep), .strb(strb)
  );

  sram_rd_path #(.DATA_W(DATA_W)) rd_i (
    .clk(clk), .rstN(rstN), .strb(strb), .oeN(oeN),
    .arrRdData(arrRdData), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/sram_burst_ctl_tb.sv
module sram_burst_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic adspN = 1, adscN = 1, advN = 1, ce1N = 1, ce2 = 0, ce3N = 1;
  logic gwN = 1, bweN = 1, oeN = 0, sleep = 0;
  logic [LANES-1:0]  bwN = '1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] arrRdData;
  logic [ADDR_W-1:0] arrAddr;
  logic              arrRd, arrWr, burstStep, dqOe;
  logic [LANES-1:0]  arrByteEn;
  logic [DATA_W-1:0] dqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] memData(input logic [ADDR_W-1:0] a);
    return {a[8:0], ~a[8:0]};
  endfunction

  // array model: combinational read of the registered address
  assign arrRdData = memData(arrAddr);

  sram_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .oeN(oeN), .sleep(sleep), .addrIn(addrIn), .arrRdData(arrRdData),
    .arrAddr(arrAddr), .arrRd(arrRd), .arrWr(arrWr), .arrByteEn(arrByteEn),
    .burstStep(burstStep), .dqOut(dqOut), .dqOe(dqOe)
  );

  typedef struct packed {
    logic adspN, adscN, advN, ce1N, ce2, ce3N, gwN, bweN;
    logic [1:0]  bwN;
    logic [15:0] addr;
    logic        expRd, expWr;
    logic [1:0]  expBe;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,16'h0010,1'b1,1'b0,2'b00,4'd6}, // R6 adsp start reads
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,16'h0011,1'b0,1'b1,2'b11,4'd4}, // R4 global write
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b10,16'h0012,1'b0,1'b1,2'b01,4'd5}, // R5 lane 0
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b01,16'h0013,1'b0,1'b1,2'b10,4'd5}, // R5 lane 1
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b00,16'h0014,1'b1,1'b0,2'b00,4'd5}, // R5 bweN high reads
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,16'h0015,1'b1,1'b0,2'b00,4'd2}, // R2 enables ignored
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'b11,16'h0020,1'b0,1'b0,2'b00,4'd1}, // R1 ce2 low
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,16'h0021,1'b0,1'b0,2'b00,4'd1}, // R1 stays deselected
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,16'h0030,1'b0,1'b0,2'b00,4'd3}, // R3 adsp ignored
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,16'h0040,1'b0,1'b1,2'b11,4'd6}, // R6 adsc write
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,16'h0050,1'b1,1'b0,2'b00,4'd3}, // R3 adsp priority
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,16'h0060,1'b0,1'b0,2'b00,4'd3}, // R3 adsc deselects
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,16'h0061,1'b0,1'b0,2'b00,4'd3}, // R3 deselect held
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b11,16'h0070,1'b0,1'b0,2'b00,4'd1}, // R1 ce3N high
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,16'h0080,1'b1,1'b0,2'b00,4'd1}  // R1 selected
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic sp, input logic sc, input logic av,
                       input logic c1, input logic c2, input logic c3,
                       input logic g, input logic bwe, input logic [1:0] bw,
                       input logic [15:0] a);
    adspN = sp; adscN = sc; advN = av; ce1N = c1; ce2 = c2; ce3N = c3;
    gwN = g; bweN = bwe; bwN = bw; addrIn = a;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    check(arrRd == 0 && arrWr == 0 && arrByteEn == 0 && dqOe == 0 && burstStep == 0,
          "R13", {arrRd, arrWr, arrByteEn, dqOe, burstStep}, 0);
    rstN = 1;

    // stimulus table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i].adspN, VECS[i].adscN, VECS[i].advN, VECS[i].ce1N, VECS[i].ce2,
            VECS[i].ce3N, VECS[i].gwN, VECS[i].bweN, VECS[i].bwN, VECS[i].addr);
      step();
      check(arrRd == VECS[i].expRd && arrWr == VECS[i].expWr && arrByteEn == VECS[i].expBe
            && (!(VECS[i].expRd || VECS[i].expWr) || arrAddr == VECS[i].addr),
            $sformatf("R%0d vec%0d", VECS[i].req, i),
            {arrRd, arrWr, arrByteEn, arrAddr},
            {VECS[i].expRd, VECS[i].expWr, VECS[i].expBe, VECS[i].addr});
    end

    // R7 / R9 pipeline from a deselected state
    @(negedge clk); drive(1,0,1,0,0,0,1,1,2'b11,16'h0000); step();
    @(negedge clk); drive(1,1,1,0,1,0,1,1,2'b11,16'h0000); step();
    @(negedge clk); drive(0,1,1,0,1,0,1,1,2'b11,16'h0100); step();
    check(arrRd == 1 && arrAddr == 16'h0100, "R7 strobe", {arrRd, arrAddr}, {1'b1, 16'h0100});
    check(dqOe == 0, "R9 first read masked", dqOe, 0);
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0101); step();
    check(dqOe == 1 && dqOut == memData(16'h0100), "R7 data", {dqOe, dqOut},
          {1'b1, memData(16'h0100)});
    @(negedge clk); drive(1,1,0,0,1,0,0,1,2'b11,16'h0102); step();
    check(dqOe == 1 && dqOut == memData(16'h0101), "R7 data 2", {dqOe, dqOut},
          {1'b1, memData(16'h0101)});
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0103); step();
    check(dqOe == 0, "R9 after write", dqOe, 0);
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0104); step();
    check(dqOe == 1 && dqOut == memData(16'h0103), "R7 data 3", {dqOe, dqOut},
          {1'b1, memData(16'h0103)});

    // R8 asynchronous output enable
    #2 oeN = 1; #1;
    check(dqOe == 0, "R8 oe high", dqOe, 0);
    oeN = 0; #1;
    check(dqOe == 1, "R8 oe low", dqOe, 1);

    // R12 burst step (selected, continue)
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0105); #1;
    check(burstStep == 1, "R12 advance", burstStep, 1);
    advN = 1; #1;
    check(burstStep == 0, "R12 hold", burstStep, 0);
    advN = 0; adspN = 0; #1;
    check(burstStep == 0, "R12 load", burstStep, 0);
    adspN = 1; adscN = 0; ce2 = 0; step();
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0106); #1;
    check(burstStep == 0, "R12 deselected", burstStep, 0);

    // R10 / R11 sleep entry and exit
    @(negedge clk); drive(0,1,1,0,1,0,1,1,2'b11,16'h0200); step();
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0201); sleep = 1; step();
    check(arrRd == 1, "R10 edge 1 processed", arrRd, 1);
    @(negedge clk); drive(1,1,0,0,1,0,1,1,2'b11,16'h0202); step();
    check(arrRd == 1 && dqOe == 0, "R10 edge 2 processed, pins off", {arrRd, dqOe}, 2'b10);
    @(negedge clk); drive(0,1,1,0,1,0,0,1,2'b11,16'h0300); step();
    check(arrRd == 0 && arrWr == 0 && dqOe == 0, "R10 asleep", {arrRd, arrWr, dqOe}, 0);
    step();
    @(negedge clk); sleep = 0; step();
    check(arrRd == 0 && arrWr == 0, "R11 release edge 1", {arrRd, arrWr}, 0);
    step();
    check(arrRd == 0 && dqOe == 0, "R11 release edge 2", {arrRd, dqOe}, 0);
    step();
    check(arrRd == 1 && arrAddr == 16'h0300, "R11 usable", {arrRd, arrAddr}, {1'b1, 16'h0300});
    @(negedge clk); drive(1,1,1,0,1,0,1,1,2'b11,16'h0301); step();
    check(dqOe == 1 && dqOut == memData(16'h0300), "R11 read after wake", {dqOe, dqOut},
          {1'b1, memData(16'h0300)});

    // R13 reset during activity
    @(negedge clk); rstN = 0; #1;
    check(arrRd == 0 && dqOe == 0, "R13 mid-run", {arrRd, dqOe}, 0);
    @(negedge clk); rstN = 1; drive(1,1,0,0,1,0,1,1,2'b11,16'h0400); step();
    check(arrRd == 0, "R13 deselected after reset", arrRd, 0);

    finishRun();
  end
endmodule